// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Resolver

This block combines two eight-input interrupt resolvers into one priority tree. The upper (master) resolver takes request lines 0 to 7. The lower (slave) resolver takes lines 8 to 15. The slave's "has a winner" signal feeds master input 2, so fifteen external request lines are usable. Each resolver keeps a pending-request vector and an in-service vector. It picks its winner by fixed priority, where the lowest line number is most urgent. It raises its output only when that winner outranks everything already in service.

The processor side sees one interrupt line. When the processor pulses the acknowledge strobe, the block returns a registered vector byte. The byte is built from the vector base of the resolver that owns the winning line, with the line number in its low three bits. If the master has nothing to grant, or it grants the cascade input while the slave has nothing, the block substitutes line 7 of the resolver concerned. A poll strobe returns the winning line number of a chosen resolver without performing an acknowledge. A non-specific end-of-interrupt strobe retires the most urgent in-service line of a chosen resolver. A nesting option on the master lets urgent slave requests nest inside a slave request that is already in service.

Top module: `pic_cascade`

## Requirements
- R1: A low-to-high transition on an external request line latches a request. Keeping the line high after that request has been served raises no new request.
- R2: Fixed priority applies, with the lower global line number winning and the cascade input ranking between master lines 1 and 3. A line whose `mask_i` bit is 1 takes no part in selection while masked, but its latched request is kept.
- R3: `cpu_int_o` is high exactly when the master's winner outranks the master's most urgent in-service line. After an acknowledge moves that winner into service, the output drops in the following cycle.
- R4: An acknowledge of a master line L (L not 2) returns the byte {master base, L[2:0]} on `vec_o`, one cycle after the `inta_i` cycle. `vec_vld_o` is high for exactly that one cycle.
- R5: When the master grants line 2, the slave is acknowledged in the same cycle and the byte is {slave base, slave line[2:0]}.
- R6: When the master grants line 2 but the slave has no winner, the byte is {slave base, 3'b111} and the slave's state is left unchanged.
- R7: An acknowledge while the master has no winner returns {master base, 3'b111} and changes no state.
- R8: External request bit 2 has no effect: it never raises `cpu_int_o` and never produces a vector.
- R9: With `sfnm_i` high, master in-service bit 2 is ignored when computing master priority, so a more urgent slave request is granted while a slave line is in service. With `sfnm_i` low it is held off.
- R10: `eoi_i` clears the most urgent in-service bit of the resolver named by `eoi_sel_i` (0 = master, 1 = slave). This re-enables less urgent pending lines.
- R11: A poll (`poll_i`, with `poll_sel_i` 0 = master, 1 = slave) returns the selected resolver's winning line number zero-extended on `vec_o`, with `vec_vld_o` high for one cycle. It clears that line's request and in-service bits and sets no in-service bit. If there is no winner it returns 7.
- R12: A successful slave poll also clears master request bit 2 and master in-service bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | 16 | Request levels, bits 0-7 master, 8-15 slave; bit 2 unused |
| mask_i | input | 16 | Per-line mask, 1 excludes the line from selection |
| mbase_i | input | 5 | Master vector base (upper five vector bits) |
| sbase_i | input | 5 | Slave vector base (upper five vector bits) |
| sfnm_i | input | 1 | Master ignores its in-service bit 2 for priority |
| inta_i | input | 1 | Acknowledge strobe, one cycle |
| poll_i | input | 1 | Poll strobe, one cycle |
| poll_sel_i | input | 1 | Poll target: 0 master, 1 slave |
| eoi_i | input | 1 | Non-specific end-of-interrupt strobe |
| eoi_sel_i | input | 1 | EOI target: 0 master, 1 slave |
| cpu_int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector byte or poll result |
| vec_vld_o | output | 1 | High for the cycle after an acknowledge or poll |

## Verification
The bench aims at both spurious paths. For the slave path it masks a slave line after the cascade request has reached the master. A design that took the vector from the master base, or acknowledged a slave line anyway, would return the wrong byte or lose the slave request. The bench runs the nesting test with the option on and off, so a design that never ignores the cascade in-service bit, or always ignores it, fails one of the two runs. It also looks for poll side effects: it checks that a slave poll clears master request 2 and in-service 2, and that a poll sets no in-service bit. A design that missed either would block a later master line 3 or line 6.

// File: rtl/pic_cascade_pkg.sv
// Shared constants for the cascaded interrupt resolver.
// Assumes eight lines per resolver and a byte-wide vector.
package pic_cascade_pkg;
    localparam int PIC_LINES  = 8;
    localparam int PIC_BASE_W = 5;
    localparam int PIC_CASC   = 2;
endpackage

// File: rtl/pic_prio_find.sv
// Lowest-index set-bit finder (index 0 is most urgent).
// Assumes N is a power of two; idx is zero when nothing is set.
module pic_prio_find #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    // scan from the least urgent end so the most urgent set bit wins
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/pic_resolver.sv
// One eight-line priority resolver: edge capture, pending and in-service
// vectors, winner selection against the current in-service level.
// Assumes the parent presents at most one of ack / poll_clr / eoi per cycle.
// On the master, casc_set latches the cascade line and casc_clr clears it.
module pic_resolver #(
    parameter int N         = 8,
    parameter int IW        = $clog2(N),
    parameter int CASC      = 2,
    parameter bit IS_MASTER = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_lvl,
    input  logic [N-1:0]  mask,
    input  logic          sfnm,
    input  logic          casc_set,
    input  logic          casc_clr,
    input  logic          ack,
    input  logic          poll_clr,
    input  logic          eoi,
    output logic          int_o,
    output logic [IW-1:0] win_o
);
    localparam logic [N-1:0] CASC_BIT = {{(N-1){1'b0}}, 1'b1} << CASC;

    logic [N-1:0]  last_q, irr_q, isr_q, irr_n, isr_n;
    logic [N-1:0]  cand, isr_view;
    logic          win_any, cur_any, top_any;
    logic [IW-1:0] win_idx, cur_idx, top_idx;

    assign cand     = irr_q & ~mask;
    // nesting option drops the cascade in-service bit on the master only
    assign isr_view = (IS_MASTER && sfnm) ? (isr_q & ~CASC_BIT) : isr_q;

    pic_prio_find #(.N(N), .IW(IW)) u_win (.vec(cand),     .any(win_any), .idx(win_idx));
    pic_prio_find #(.N(N), .IW(IW)) u_cur (.vec(isr_view), .any(cur_any), .idx(cur_idx));
    pic_prio_find #(.N(N), .IW(IW)) u_top (.vec(isr_q),    .any(top_any), .idx(top_idx));

    assign int_o = win_any && (!cur_any || (win_idx < cur_idx));
    assign win_o = win_idx;

    // next-state of the pending and in-service vectors
    always_comb begin
        irr_n = irr_q | (req_lvl & ~last_q) | (casc_set ? CASC_BIT : '0);
        isr_n = isr_q;
        if (ack && int_o) begin
            isr_n[win_idx] = 1'b1;
            irr_n[win_idx] = 1'b0;
        end else if (poll_clr && int_o) begin
            isr_n[win_idx] = 1'b0;
            irr_n[win_idx] = 1'b0;
        end else if (eoi && top_any) begin
            isr_n[top_idx] = 1'b0;
        end
        if (casc_clr) begin
            irr_n = irr_n & ~CASC_BIT;
            isr_n = isr_n & ~CASC_BIT;
        end
    end

    // state registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
            irr_q  <= '0;
            isr_q  <= '0;
        end else begin
            last_q <= req_lvl;
            irr_q  <= irr_n;
            isr_q  <= isr_n;
        end
    end

    // R3: a granted acknowledge puts the winner into service
    a_r3_ack_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_o) |=> isr_q[$past(win_o)]);

    // R11: a granted poll leaves neither request nor in-service for that line
    a_r11_poll_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_clr && int_o) |=> (!irr_q[$past(win_o)] && !isr_q[$past(win_o)]));

    // R10: an end-of-interrupt retires exactly one in-service bit
    a_r10_eoi_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !ack && !poll_clr && !casc_clr && (isr_q != '0))
        |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));

    // R1: no in-service bit appears without an acknowledge
    a_r1_isr_only_by_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> ((isr_q & ~$past(isr_q)) == '0));
endmodule

// File: rtl/pic_cascade.sv
// Two resolvers in cascade: slave winner feeds master line 2.
// Decodes the acknowledge, poll and end-of-interrupt strobes (precedence
// acknowledge > poll > eoi), builds the registered vector byte with
// spurious substitution at either level. External request bit 2 is unused.
module pic_cascade #(
    parameter int LINES  = pic_cascade_pkg::PIC_LINES,
    parameter int BASE_W = pic_cascade_pkg::PIC_BASE_W,
    parameter int CASC   = pic_cascade_pkg::PIC_CASC,
    parameter int IDX_W  = $clog2(LINES),
    parameter int VEC_W  = BASE_W + IDX_W,
    parameter int TOTAL  = 2 * LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TOTAL-1:0]  irq_i,
    input  logic [TOTAL-1:0]  mask_i,
    input  logic [BASE_W-1:0] mbase_i,
    input  logic [BASE_W-1:0] sbase_i,
    input  logic              sfnm_i,
    input  logic              inta_i,
    input  logic              poll_i,
    input  logic              poll_sel_i,
    input  logic              eoi_i,
    input  logic              eoi_sel_i,
    output logic              cpu_int_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic              vec_vld_o
);
    localparam logic [IDX_W-1:0] SPUR     = IDX_W'(LINES - 1);
    localparam logic [IDX_W-1:0] CASC_IDX = IDX_W'(CASC);
    localparam logic [LINES-1:0] CASC_BIT = {{(LINES-1){1'b0}}, 1'b1} << CASC;

    logic [1:0][LINES-1:0] lvl_w, msk_w;
    logic [1:0]            ack_w, poll_w, eoi_w, cset_w, cclr_w, int_w;
    logic [1:0][IDX_W-1:0] win_w;
    logic                  do_ack, do_poll, do_eoi, m_casc;
    logic [VEC_W-1:0]      vec_n, vec_q;
    logic                  vld_q;

    assign do_ack  = inta_i;
    assign do_poll = !inta_i && poll_i;
    assign do_eoi  = !inta_i && !poll_i && eoi_i;
    assign m_casc  = int_w[0] && (win_w[0] == CASC_IDX);

    // per-resolver strobe and input routing (index 0 master, 1 slave)
    always_comb begin
        lvl_w[0]  = irq_i[LINES-1:0] & ~CASC_BIT;
        lvl_w[1]  = irq_i[TOTAL-1:LINES];
        msk_w[0]  = mask_i[LINES-1:0];
        msk_w[1]  = mask_i[TOTAL-1:LINES];
        ack_w[0]  = do_ack;
        ack_w[1]  = do_ack && m_casc;
        poll_w[0] = do_poll && !poll_sel_i;
        poll_w[1] = do_poll && poll_sel_i;
        eoi_w[0]  = do_eoi && !eoi_sel_i;
        eoi_w[1]  = do_eoi && eoi_sel_i;
        cset_w[0] = int_w[1];
        cset_w[1] = 1'b0;
        cclr_w[0] = do_poll && poll_sel_i && int_w[1];
        cclr_w[1] = 1'b0;
    end

    for (genvar g = 0; g < 2; g++) begin : g_res
        pic_resolver #(
            .N(LINES), .IW(IDX_W), .CASC(CASC), .IS_MASTER(g == 0)
        ) u_res (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_lvl  (lvl_w[g]),
            .mask     (msk_w[g]),
            .sfnm     (sfnm_i),
            .casc_set (cset_w[g]),
            .casc_clr (cclr_w[g]),
            .ack      (ack_w[g]),
            .poll_clr (poll_w[g]),
            .eoi      (eoi_w[g]),
            .int_o    (int_w[g]),
            .win_o    (win_w[g])
        );
    end

    // vector byte selection with spurious substitution at each level
    always_comb begin
        vec_n = vec_q;
        if (do_ack) begin
            if (!int_w[0])      vec_n = {mbase_i, SPUR};
            else if (m_casc)    vec_n = {sbase_i, int_w[1] ? win_w[1] : SPUR};
            else                vec_n = {mbase_i, win_w[0]};
        end else if (do_poll) begin
            vec_n = {{BASE_W{1'b0}}, int_w[poll_sel_i] ? win_w[poll_sel_i] : SPUR};
        end
    end

    // output register and one-cycle valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vec_q <= vec_n;
            vld_q <= do_ack || do_poll;
        end
    end

    assign cpu_int_o = int_w[0];
    assign vec_o     = vec_q;
    assign vec_vld_o = vld_q;

    // R4: the valid flag lasts one cycle after a strobe
    a_r4_vld_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (!inta_i && !poll_i) |=> !vec_vld_o);

    // R7: acknowledge with nothing granted yields master base plus 7
    a_r7_spurious_master: assert property (@(posedge clk) disable iff (!rst_n)
        (inta_i && !cpu_int_o) |=> (vec_o == {$past(mbase_i), SPUR}));

    // R5: a cascade grant takes its upper bits from the slave base
    a_r5_slave_base: assert property (@(posedge clk) disable iff (!rst_n)
        (inta_i && m_casc) |=> (vec_o[VEC_W-1 -: BASE_W] == $past(sbase_i)));
endmodule

// File: tb/pic_cascade_tb.sv
// Bench for pic_cascade: a vector table over every usable line, then
// directed tests for priority, spurious paths, nesting option and poll.
module pic_cascade_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;
    localparam int NVEC       = 15;
    // {line, expected vector} with master base 5'h01 and slave base 5'h0E
    localparam logic [11:0] TBL [NVEC] = '{
        {4'd0, 8'h08}, {4'd1, 8'h09}, {4'd3, 8'h0B}, {4'd4, 8'h0C},
        {4'd5, 8'h0D}, {4'd6, 8'h0E}, {4'd7, 8'h0F}, {4'd8, 8'h70},
        {4'd9, 8'h71}, {4'd10, 8'h72}, {4'd11, 8'h73}, {4'd12, 8'h74},
        {4'd13, 8'h75}, {4'd14, 8'h76}, {4'd15, 8'h77}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq = '0, mask = '0;
    logic        sfnm = 1'b0, inta = 1'b0, poll = 1'b0, poll_sel = 1'b0;
    logic        eoi = 1'b0, eoi_sel = 1'b0;
    logic        cpu_int, vld;
    logic [7:0]  vec;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pic_cascade dut_i (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .mask_i(mask),
        .mbase_i(5'h01), .sbase_i(5'h0E), .sfnm_i(sfnm),
        .inta_i(inta), .poll_i(poll), .poll_sel_i(poll_sel),
        .eoi_i(eoi), .eoi_sel_i(eoi_sel),
        .cpu_int_o(cpu_int), .vec_o(vec), .vec_vld_o(vld)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; step(); step(); rst_n = 1'b1;
    endtask

    task automatic pulse(input logic [15:0] pat);
        irq = irq | pat; step(); irq = irq & ~pat; step();
    endtask

    task automatic ack();
        inta = 1'b1; step(); inta = 1'b0;
    endtask

    task automatic do_poll(input logic sel);
        poll = 1'b1; poll_sel = sel; step(); poll = 1'b0;
    endtask

    task automatic do_eoi(input logic sel);
        eoi = 1'b1; eoi_sel = sel; step(); eoi = 1'b0;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        step(); step(); rst_n = 1'b1;
        // reset state
        chk("R3 reset cpu_int", {7'd0, cpu_int}, 8'h00);
        chk("R4 reset valid", {7'd0, vld}, 8'h00);
        chk("R4 reset vector", vec, 8'h00);

        // table walk over all fifteen usable lines
        for (int k = 0; k < NVEC; k++) begin
            pulse(16'h1 << TBL[k][11:8]);
            chk("R3 raise", {7'd0, cpu_int}, 8'h01);
            ack();
            chk(TBL[k][11:8] >= 8 ? "R5 slave vector" : "R4 master vector", vec, TBL[k][7:0]);
            chk("R4 valid", {7'd0, vld}, 8'h01);
            chk("R3 drop after ack", {7'd0, cpu_int}, 8'h00);
            step();
            chk("R4 valid one cycle", {7'd0, vld}, 8'h00);
            if (TBL[k][11:8] >= 8) do_eoi(1'b1);
            do_eoi(1'b0);
        end

        // R7 master spurious
        ack();
        chk("R7 spurious master", vec, 8'h0F);
        chk("R7 no grant after", {7'd0, cpu_int}, 8'h00);

        // R8 external bit 2 ignored
        pulse(16'h0004);
        chk("R8 bit2 no int", {7'd0, cpu_int}, 8'h00);
        ack();
        chk("R8 bit2 no vector", vec, 8'h0F);

        // R2 priority among master lines, R10 end-of-interrupt
        pulse(16'h000A);
        ack();
        chk("R2 line1 beats 3", vec, 8'h09);
        chk("R10 line3 held by isr1", {7'd0, cpu_int}, 8'h00);
        do_eoi(1'b0);
        chk("R10 eoi releases line3", {7'd0, cpu_int}, 8'h01);
        ack();
        chk("R10 line3 vector", vec, 8'h0B);
        do_eoi(1'b0);

        // R2 cascade rank against master lines 1 and 3
        pulse(16'h0102);
        ack();
        chk("R2 line1 beats cascade", vec, 8'h09);
        do_eoi(1'b0);
        chk("R2 cascade follows", {7'd0, cpu_int}, 8'h01);
        ack();
        chk("R5 cascade vector", vec, 8'h70);
        do_eoi(1'b1); do_eoi(1'b0);
        pulse(16'h0108);
        ack();
        chk("R2 cascade beats line3", vec, 8'h70);
        do_eoi(1'b1); do_eoi(1'b0);
        ack();
        chk("R2 line3 after cascade", vec, 8'h0B);
        do_eoi(1'b0);

        // R2 masking keeps the latched request
        mask[4] = 1'b1;
        pulse(16'h0010);
        chk("R2 masked no int", {7'd0, cpu_int}, 8'h00);
        mask[4] = 1'b0; step();
        chk("R2 unmasked int", {7'd0, cpu_int}, 8'h01);
        ack();
        chk("R2 unmasked vector", vec, 8'h0C);
        do_eoi(1'b0);

        // R6 slave spurious: slave line masked after cascade request latched
        pulse(16'h0200);
        mask[9] = 1'b1; step();
        chk("R6 cascade still pending", {7'd0, cpu_int}, 8'h01);
        ack();
        chk("R6 spurious slave vector", vec, 8'h77);
        do_eoi(1'b1); do_eoi(1'b0);
        mask[9] = 1'b0; step(); step();
        chk("R6 slave request kept", {7'd0, cpu_int}, 8'h01);
        ack();
        chk("R6 slave line9 vector", vec, 8'h71);
        do_eoi(1'b1); do_eoi(1'b0);

        // R1 held level makes a single request
        irq[5] = 1'b1; step(); step();
        ack();
        chk("R1 held line vector", vec, 8'h0D);
        do_eoi(1'b0); step(); step();
        chk("R1 no re-request", {7'd0, cpu_int}, 8'h00);
        irq[5] = 1'b0; step();

        // R9 nesting option off then on
        do_reset();
        pulse(16'h0400); ack();
        chk("R9 first slave", vec, 8'h72);
        pulse(16'h0100);
        chk("R9 off holds nesting", {7'd0, cpu_int}, 8'h00);
        sfnm = 1'b1; do_reset();
        pulse(16'h0400); ack();
        chk("R9 first slave on", vec, 8'h72);
        pulse(16'h0100);
        chk("R9 on nests", {7'd0, cpu_int}, 8'h01);
        ack();
        chk("R9 nested vector", vec, 8'h70);
        sfnm = 1'b0; do_reset();

        // R11 poll
        do_poll(1'b0);
        chk("R11 empty poll", vec, 8'h07);
        chk("R11 poll valid", {7'd0, vld}, 8'h01);
        pulse(16'h0020);
        do_poll(1'b0);
        chk("R11 poll line5", vec, 8'h05);
        chk("R11 request cleared", {7'd0, cpu_int}, 8'h00);
        pulse(16'h0040);
        chk("R11 no isr set by poll", {7'd0, cpu_int}, 8'h01);
        ack();
        chk("R11 line6 vector", vec, 8'h0E);
        do_eoi(1'b0);

        // R12 slave poll clears master cascade request and in-service
        pulse(16'h1000);
        do_poll(1'b1);
        chk("R11 slave poll value", vec, 8'h04);
        chk("R12 cascade request cleared", {7'd0, cpu_int}, 8'h00);
        pulse(16'h2000); ack();
        chk("R5 line13 vector", vec, 8'h75);
        pulse(16'h0100);
        do_poll(1'b1);
        chk("R11 slave poll line8", vec, 8'h00);
        pulse(16'h0008);
        chk("R12 cascade isr cleared", {7'd0, cpu_int}, 8'h01);
        ack();
        chk("R12 line3 vector", vec, 8'h0B);

        done = 1'b1;
        finish_run();
    end
endmodule